// File: doc/BRIEF.md
# Dual-Port Byte FIFO with Threshold Alerts

This block is a byte-wide first-in first-out store of 64 entries that sits between a host register port and an internal serial engine. Either side may push bytes in and pop bytes out in any cycle. The block keeps a fill count, which the host reads through a level register. It also raises a sticky overflow error when a push arrives while the store is full, and it drives two level-sensitive alert outputs that a separate interrupt block consumes.

The alerts compare the fill count against a programmable 6-bit water level. The nearly-full alert looks at the free space and the nearly-empty alert looks at the stored count. Writing a one to the top bit of the level register flushes the store and clears the overflow error in the same step. That bit is a command and never reads back as one.

When pushes from both sides land in the same cycle, the host byte is stored ahead of the engine byte. When pops from both sides land in the same cycle, the host receives the older byte. Room and availability are judged on the contents held at the start of the cycle.

Top module: `wl_byte_fifo`

## Requirements
- R1: After reset the fill count is 0, `lo_alert` is 1, `hi_alert` is 0, `ovfl_err` is 0, and `wl_rdata` reads 8.
- R2: Bytes leave in the order they entered. Popped data appears on `host_rdata`/`eng_rdata` combinationally during the cycle the pop is asserted. In a cycle with two pushes the host byte is stored first. In a cycle with two pops the host gets the older byte.
- R3: Each accepted push adds one to the count and each accepted pop subtracts one. A push and a pop in the same cycle leave the count unchanged. The count is read in `lvl_rdata` bits 6..0, with bit 7 reading 0.
- R4: A pop while no byte is available returns 0 on that side's read data and does not change the count.
- R5: A push judged against a full store, counting any push from the other side earlier in the same cycle, is discarded and sets `ovfl_err`. `ovfl_err` stays set until a flush. A pop in the same cycle does not make room.
- R6: `hi_alert` is 1 exactly when (64 − count) ≤ water level. For example, with water level 4 a count of 60 gives 1 and a count of 59 gives 0.
- R7: `lo_alert` is 1 exactly when count ≤ water level. For example, with water level 4 a count of 4 gives 1 and a count of 5 gives 0.
- R8: A write to the level register with bit 7 set empties the store and clears `ovfl_err`, both seen in the next cycle. A write with bit 7 clear has no effect.
- R9: The water level is held in `wl_wdata` bits 5..0. Bits 7..6 of a write are ignored, and `wl_rdata` returns the level in bits 5..0 with bits 7..6 reading 0.
- R10: A flush in the same cycle as pushes or pops wins. The pushes are not stored, the pops return 0, and no overflow is recorded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_push | input | 1 | Host push request |
| host_wdata | input | 8 | Host push byte |
| host_pop | input | 1 | Host pop request |
| host_rdata | output | 8 | Host popped byte (0 if none) |
| eng_push | input | 1 | Engine push request |
| eng_wdata | input | 8 | Engine push byte |
| eng_pop | input | 1 | Engine pop request |
| eng_rdata | output | 8 | Engine popped byte (0 if none) |
| lvl_we | input | 1 | Level register write strobe |
| lvl_wdata | input | 8 | Level register write data (bit 7 = flush) |
| lvl_rdata | output | 8 | Fill count in bits 6..0, bit 7 reads 0 |
| wl_we | input | 1 | Water level register write strobe |
| wl_wdata | input | 8 | Water level in bits 5..0 |
| wl_rdata | output | 8 | Current water level |
| hi_alert | output | 1 | Nearly-full alert |
| lo_alert | output | 1 | Nearly-empty alert |
| ovfl_err | output | 1 | Sticky overflow error |

## Verification
The hardest situations to reach are the alert edges at the extreme water levels. At level 0 the nearly-full alert fires only when the store is completely full. At level 63 both alerts are high over almost the whole range. The bench gets there by sweeping the water level over 0, 4, 8, 32 and 63, and for each value filling the store one byte at a time from empty to full. It then pushes into the full store, drains it completely and pops once more from empty, checking the count and both alerts against arithmetic on a queue model at every step. Mixed cycles with two pushes, two pops, a push against a pop, and a flush colliding with traffic cover the same-cycle ordering rules.

// File: rtl/wlf_pkg.sv
package wlf_pkg;
  // width of the software-visible registers
  localparam int unsigned REG_W     = 8;
  // position of the flush command in the level register
  localparam int unsigned FLUSH_BIT = REG_W - 1;

  // per-cycle acceptance of each request
  typedef struct packed {
    logic host_push;
    logic eng_push;
    logic host_pop;
    logic eng_pop;
  } wlf_acc_t;
endpackage

// File: rtl/wlf_store.sv
module wlf_store #(
  parameter int unsigned DEPTH = 64,
  parameter int unsigned DW    = 8,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we_a,
  input  logic [AW-1:0] wa_a,
  input  logic [DW-1:0] wd_a,
  input  logic          we_b,
  input  logic [AW-1:0] wa_b,
  input  logic [DW-1:0] wd_b,
  input  logic [AW-1:0] ra_a,
  input  logic [AW-1:0] ra_b,
  output logic [DW-1:0] rd_a,
  output logic [DW-1:0] rd_b
);
  logic [DW-1:0] mem [DEPTH];

  // storage carries no reset; both write ports never target one slot
  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (we_a && (wa_a == AW'(i))) begin
        mem[i] <= wd_a;
      end else if (we_b && (wa_b == AW'(i))) begin
        mem[i] <= wd_b;
      end
    end
  end

  assign rd_a = mem[ra_a];
  assign rd_b = mem[ra_b];
endmodule

// File: rtl/wlf_ctrl.sv
module wlf_ctrl
  import wlf_pkg::*;
#(
  parameter int unsigned DEPTH = 64,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned LW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          host_push_req,
  input  logic          eng_push_req,
  input  logic          host_pop_req,
  input  logic          eng_pop_req,
  input  logic          flush,
  output wlf_acc_t      acc,
  output logic [AW-1:0] wr_ptr,
  output logic [AW-1:0] rd_ptr,
  output logic [LW-1:0] level,
  output logic          ovfl
);
  localparam logic [LW:0] DEPTH_X = (LW+1)'(DEPTH);

  logic [AW-1:0] wr_ptr_nx, rd_ptr_nx;
  logic [LW-1:0] level_nx;
  logic          ovfl_nx;
  logic          reject;
  logic [1:0]    push_n, pop_n;
  logic          upd_en;

  // acceptance, judged against the contents at the start of the cycle
  always_comb begin
    acc.host_push = !flush && host_push_req && ({1'b0, level} < DEPTH_X);
    acc.eng_push  = !flush && eng_push_req &&
                    (({1'b0, level} + (LW+1)'(acc.host_push)) < DEPTH_X);
    acc.host_pop  = !flush && host_pop_req && (level != '0);
    acc.eng_pop   = !flush && eng_pop_req && (level > LW'(acc.host_pop));
    reject        = !flush && ((host_push_req && !acc.host_push) ||
                               (eng_push_req && !acc.eng_push));
    push_n        = {1'b0, acc.host_push} + {1'b0, acc.eng_push};
    pop_n         = {1'b0, acc.host_pop} + {1'b0, acc.eng_pop};
  end

  // next state
  always_comb begin
    if (flush) begin
      wr_ptr_nx = '0;
      rd_ptr_nx = '0;
      level_nx  = '0;
      ovfl_nx   = 1'b0;
    end else begin
      wr_ptr_nx = wr_ptr + AW'(push_n);
      rd_ptr_nx = rd_ptr + AW'(pop_n);
      level_nx  = level + LW'(push_n) - LW'(pop_n);
      ovfl_nx   = ovfl | reject;
    end
    upd_en = flush | reject | (push_n != 2'd0) | (pop_n != 2'd0);
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
      ovfl   <= 1'b0;
    end else if (upd_en) begin
      wr_ptr <= wr_ptr_nx;
      rd_ptr <= rd_ptr_nx;
      level  <= level_nx;
      ovfl   <= ovfl_nx;
    end
  end

  AST_PTR_DISTANCE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ptr - rd_ptr) == level[AW-1:0]); // R3
  AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    {1'b0, level} <= DEPTH_X); // R5
  AST_OVFL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (ovfl && !flush) |=> ovfl); // R5
  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (level == '0) && !ovfl); // R8
endmodule

// File: rtl/wlf_alerts.sv
module wlf_alerts #(
  parameter int unsigned DEPTH    = 64,
  parameter int unsigned WLW      = 6,
  parameter int unsigned WL_RESET = 8,
  localparam int unsigned LW      = $clog2(DEPTH) + 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wl_we,
  input  logic [WLW-1:0] wl_wd,
  input  logic [LW-1:0]  level,
  output logic [WLW-1:0] wl,
  output logic           hi,
  output logic           lo
);
  logic [WLW-1:0] wl_nx;
  logic [LW-1:0]  free_cnt;

  always_comb begin
    wl_nx = wl_we ? wl_wd : wl;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wl <= WLW'(WL_RESET);
    end else if (wl_we) begin
      wl <= wl_nx;
    end
  end

  always_comb begin
    free_cnt = LW'(DEPTH) - level;
    hi       = ({1'b0, free_cnt} <= (LW+1)'(wl));
    lo       = ({1'b0, level} <= (LW+1)'(wl));
  end

  AST_WL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !wl_we |=> $stable(wl)); // R9
endmodule

// File: rtl/wl_byte_fifo.sv
module wl_byte_fifo
  import wlf_pkg::*;
#(
  parameter int unsigned DEPTH    = 64,
  parameter int unsigned DW       = 8,
  parameter int unsigned WLW      = 6,
  parameter int unsigned WL_RESET = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             host_push,
  input  logic [DW-1:0]    host_wdata,
  input  logic             host_pop,
  output logic [DW-1:0]    host_rdata,
  input  logic             eng_push,
  input  logic [DW-1:0]    eng_wdata,
  input  logic             eng_pop,
  output logic [DW-1:0]    eng_rdata,
  input  logic             lvl_we,
  input  logic [REG_W-1:0] lvl_wdata,
  output logic [REG_W-1:0] lvl_rdata,
  input  logic             wl_we,
  input  logic [REG_W-1:0] wl_wdata,
  output logic [REG_W-1:0] wl_rdata,
  output logic             hi_alert,
  output logic             lo_alert,
  output logic             ovfl_err
);
  localparam int unsigned AW = $clog2(DEPTH);
  localparam int unsigned LW = AW + 1;

  wlf_acc_t       acc;
  logic [AW-1:0]  wr_ptr, rd_ptr;
  logic [LW-1:0]  level;
  logic [WLW-1:0] wl;
  logic [DW-1:0]  rd_a, rd_b;
  logic           flush;
  logic           unused_bits;

  assign flush       = lvl_we & lvl_wdata[FLUSH_BIT];
  assign unused_bits = ^{lvl_wdata[FLUSH_BIT-1:0], wl_wdata[REG_W-1:WLW]};

  wlf_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk           (clk),
    .rst_n         (rst_n),
    .host_push_req (host_push),
    .eng_push_req  (eng_push),
    .host_pop_req  (host_pop),
    .eng_pop_req   (eng_pop),
    .flush         (flush),
    .acc           (acc),
    .wr_ptr        (wr_ptr),
    .rd_ptr        (rd_ptr),
    .level         (level),
    .ovfl          (ovfl_err)
  );

  wlf_store #(.DEPTH(DEPTH), .DW(DW)) u_store (
    .clk  (clk),
    .we_a (acc.host_push),
    .wa_a (wr_ptr),
    .wd_a (host_wdata),
    .we_b (acc.eng_push),
    .wa_b (wr_ptr + AW'(acc.host_push)),
    .wd_b (eng_wdata),
    .ra_a (rd_ptr),
    .ra_b (rd_ptr + AW'(acc.host_pop)),
    .rd_a (rd_a),
    .rd_b (rd_b)
  );

  wlf_alerts #(.DEPTH(DEPTH), .WLW(WLW), .WL_RESET(WL_RESET)) u_alerts (
    .clk   (clk),
    .rst_n (rst_n),
    .wl_we (wl_we),
    .wl_wd (wl_wdata[WLW-1:0]),
    .level (level),
    .wl    (wl),
    .hi    (hi_alert),
    .lo    (lo_alert)
  );

  // popped data: host takes the head, engine the next slot
  always_comb begin
    host_rdata = acc.host_pop ? rd_a : '0;
    eng_rdata  = acc.eng_pop  ? rd_b : '0;
    lvl_rdata  = REG_W'(level);
    wl_rdata   = REG_W'(wl);
  end

  AST_EMPTY_POP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (host_pop && level == '0) |-> host_rdata == '0); // R4
  AST_FULL_PUSH_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    (host_push && !flush && {1'b0, level} == (LW+1)'(DEPTH)) |=> ovfl_err); // R5
  AST_EMPTY_LO: assert property (@(posedge clk) disable iff (!rst_n)
    (level == '0) |-> (lo_alert && !(eng_pop && eng_rdata != '0))); // R7
endmodule

// File: tb/wl_byte_fifo_tb.sv
`timescale 1ns/1ps
module wl_byte_fifo_tb;
  logic       clk;
  logic       rst_n;
  logic       host_push, host_pop, eng_push, eng_pop, lvl_we, wl_we;
  logic [7:0] host_wdata, eng_wdata, lvl_wdata, wl_wdata;
  logic [7:0] host_rdata, eng_rdata, lvl_rdata, wl_rdata;
  logic       hi_alert, lo_alert, ovfl_err;

  int         n_chk;
  int         n_bad;
  logic [7:0] q[$];
  bit         m_ovf;
  int         m_wl;

  wl_byte_fifo u_dut (
    .clk(clk), .rst_n(rst_n),
    .host_push(host_push), .host_wdata(host_wdata), .host_pop(host_pop), .host_rdata(host_rdata),
    .eng_push(eng_push), .eng_wdata(eng_wdata), .eng_pop(eng_pop), .eng_rdata(eng_rdata),
    .lvl_we(lvl_we), .lvl_wdata(lvl_wdata), .lvl_rdata(lvl_rdata),
    .wl_we(wl_we), .wl_wdata(wl_wdata), .wl_rdata(wl_rdata),
    .hi_alert(hi_alert), .lo_alert(lo_alert), .ovfl_err(ovfl_err)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic idle_inputs();
    host_push = 0; host_pop = 0; eng_push = 0; eng_pop = 0;
    lvl_we = 0; wl_we = 0;
    host_wdata = 0; eng_wdata = 0; lvl_wdata = 0; wl_wdata = 0;
  endtask

  task automatic check_state();
    int lv;
    lv = q.size();
    chk("R3 level", int'(lvl_rdata), lv);
    chk("R6 hi_alert", int'(hi_alert), int'((64 - lv) <= m_wl));
    chk("R7 lo_alert", int'(lo_alert), int'(lv <= m_wl));
    chk("R5 ovfl_err", int'(ovfl_err), int'(m_ovf));
  endtask

  // one cycle of traffic; called and returns at a falling edge
  task automatic step(input bit hp, input logic [7:0] hd, input bit ep, input logic [7:0] ed,
                      input bit hr, input bit er, input bit fl);
    int n;
    bit h_take, e_take, h_in;
    logic [7:0] exp_h, exp_e;
    host_push = hp; host_wdata = hd; eng_push = ep; eng_wdata = ed;
    host_pop = hr; eng_pop = er; lvl_we = fl; lvl_wdata = fl ? 8'h80 : 8'h00;
    #1;
    n = q.size();
    h_take = !fl && hr && (n > 0);
    e_take = !fl && er && (n > (h_take ? 1 : 0));
    exp_h = h_take ? q[0] : 8'h00;
    exp_e = e_take ? q[h_take ? 1 : 0] : 8'h00;
    if (hr) chk(h_take ? "R2 host_rdata" : (fl ? "R10 host_rdata" : "R4 host_rdata"),
                int'(host_rdata), int'(exp_h));
    if (er) chk(e_take ? "R2 eng_rdata" : (fl ? "R10 eng_rdata" : "R4 eng_rdata"),
                int'(eng_rdata), int'(exp_e));
    @(posedge clk);
    if (fl) begin
      q.delete();
      m_ovf = 0;
    end else begin
      if (h_take) void'(q.pop_front());
      if (e_take) void'(q.pop_front());
      h_in = 0;
      if (hp) begin
        if (n < 64) begin q.push_back(hd); h_in = 1; end
        else m_ovf = 1;
      end
      if (ep) begin
        if (n + (h_in ? 1 : 0) < 64) q.push_back(ed);
        else m_ovf = 1;
      end
    end
    @(negedge clk);
    idle_inputs();
    check_state();
  endtask

  task automatic set_wl(input logic [7:0] v);
    wl_we = 1; wl_wdata = v;
    @(posedge clk);
    m_wl = int'(v & 8'h3f);
    @(negedge clk);
    idle_inputs();
    chk("R9 wl_rdata", int'(wl_rdata), m_wl);
    check_state();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    int wls[5];
    n_chk = 0; n_bad = 0; m_ovf = 0; m_wl = 8;
    wls = '{0, 4, 8, 32, 63};
    idle_inputs();
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 level", int'(lvl_rdata), 0);
    chk("R1 lo_alert", int'(lo_alert), 1);
    chk("R1 hi_alert", int'(hi_alert), 0);
    chk("R1 ovfl_err", int'(ovfl_err), 0);
    chk("R1 wl_rdata", int'(wl_rdata), 8);

    // sweep of water levels: fill, overflow, drain, empty pop
    foreach (wls[k]) begin
      set_wl(8'(wls[k]));
      step(0, 0, 0, 0, 0, 0, 1);
      for (int i = 0; i < 64; i++) step(1, 8'(i * 7 + wls[k]), 0, 0, 0, 0, 0);
      step(0, 0, 1, 8'hee, 0, 0, 0);           // R5 engine push into full
      step(1, 8'hdd, 0, 0, 0, 1, 0);           // R5 pop does not make room
      for (int i = 0; i < 63; i++) step(0, 0, 0, 0, 0, 1, 0);
      step(0, 0, 0, 0, 1, 1, 0);               // R4 pops from empty
      chk("R5 sticky", int'(ovfl_err), 1);
      step(0, 0, 0, 0, 0, 0, 1);               // R8 flush clears error
      chk("R8 ovfl cleared", int'(ovfl_err), 0);
    end

    // R6/R7 boundary pairs at water level 4
    set_wl(8'd4);
    for (int i = 0; i < 60; i++) step(1, 8'(i), 0, 0, 0, 0, 0);
    chk("R6 level60 hi", int'(hi_alert), 1);
    step(0, 0, 0, 0, 1, 0, 0);
    chk("R6 level59 hi", int'(hi_alert), 0);
    step(0, 0, 0, 0, 0, 0, 1);
    for (int i = 0; i < 5; i++) step(0, 0, 1, 8'(100 + i), 0, 0, 0);
    chk("R7 level5 lo", int'(lo_alert), 0);
    step(0, 0, 0, 0, 0, 1, 0);
    chk("R7 level4 lo", int'(lo_alert), 1);

    // R2 ordering with two pushes and two pops per cycle
    step(0, 0, 0, 0, 0, 0, 1);
    for (int i = 0; i < 10; i++) step(1, 8'(2 * i + 1), 1, 8'(2 * i + 2), 0, 0, 0);
    for (int i = 0; i < 10; i++) step(0, 0, 0, 0, 1, 1, 0);
    // R3 push against pop keeps level
    for (int i = 0; i < 3; i++) step(1, 8'(50 + i), 0, 0, 0, 0, 0);
    for (int i = 0; i < 8; i++) step(0, 0, 1, 8'(60 + i), 1, 0, 0);
    chk("R3 level constant", int'(lvl_rdata), 3);
    for (int i = 0; i < 8; i++) step(1, 8'(70 + i), 0, 0, 0, 1, 0);
    // R8 write with bit 7 clear is ignored
    lvl_we = 1; lvl_wdata = 8'h7f;
    @(posedge clk);
    @(negedge clk);
    idle_inputs();
    chk("R8 no flush on bit7=0", int'(lvl_rdata), 3);
    chk("R3 bit7 reads 0", int'(lvl_rdata[7]), 0);
    // R10 flush colliding with traffic
    step(1, 8'h11, 1, 8'h22, 1, 1, 1);
    chk("R10 flush wins", int'(lvl_rdata), 0);
    // R9 upper bits ignored
    set_wl(8'hff);
    set_wl(8'hc5);

    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule